// File: doc/BRIEF.md
# Link ackID Tracker with Fatal-Error Recovery

This block keeps the acknowledge-ID bookkeeping for one end of a serial point-to-point packet link. Incoming packets reach it as already framed header fields: a 5-bit ackID and a destination ID. Each packet is compared against a locally held expected ackID. A packet with a matching ackID is acknowledged at the link layer. It is passed on to the logical layer only if its destination ID equals the local base ID, or if promiscuous mode is on. Outgoing packets wait in a small queue and leave stamped with consecutive ackIDs.

An incoming ackID that differs from the expected value is fatal. The block then runs a short soft reset. It discards whatever is still waiting in the transmit queue and returns the expected ackID to zero. The transmit ackID is reloaded either with zero or, when automatic synchronization is enabled, with the partner's expected value taken from an input. When enabled, it also sends four back-to-back reset-device requests to the partner before traffic resumes.

The block also watches incoming control symbols. A run of four reset-device symbols in succession starts the same soft reset. A port-disable input holds the whole block in its reset state for as long as it is high.

Top module: `ackid_link_tracker`

## Requirements
- R1: After rst_n or while port_dis is high, exp_ackid is 0, the transmit queue is empty and the next transmitted ackID is 0. While port_dis is high, rx_ready, tx_in_ready and tx_out_valid are all low.
- R2: A packet taken on rx_valid && rx_ready with rx_ackid equal to exp_ackid raises rx_ack in that cycle. exp_ackid then increments by one modulo 32, so 31 is followed by 0.
- R3: With cfg_promisc at 0, an accepted packet whose rx_destid differs from cfg_base_id raises rx_ack but not rx_deliver. With cfg_promisc at 1, every accepted packet raises rx_deliver.
- R4: A packet whose rx_ackid differs from exp_ackid gets no rx_ack. In the next cycle recovering is high, stat_fatal is set, and rx_ready and tx_in_ready are low for the whole recovery.
- R5: Recovery discards every packet queued for transmit. When it ends, exp_ackid is 0, tx_out_valid is low, and new packets are accepted again.
- R6: With cfg_send_rst at 1, a recovery caused by a fatal error drives sym_out_rstdev high for exactly 4 consecutive cycles, and recovering stays high for 6 cycles. With cfg_send_rst at 0, or for a recovery caused by the partner, sym_out_rstdev stays low and recovering stays high for 2 cycles.
- R7: At the end of recovery the next transmit ackID is partner_ackid when cfg_auto_sync is 1, and 0 when it is 0.
- R8: peer_rst_seen pulses in the cycle of the 4th consecutive valid symbol with sym_in_rstdev at 1, and recovery starts in the next cycle without setting stat_fatal. A valid symbol with sym_in_rstdev at 0 restarts the count. Cycles with sym_in_valid low neither count nor restart it.
- R9: stat_fatal stays set after recovery ends, and it clears in the cycle after stat_clr is pulsed high.
- R10: Transmitted packets leave in push order, with tx_out_ackid rising by one modulo 32 per handshake. The queue holds QDEPTH (default 4) packets, and tx_in_ready is low while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_dis | input | 1 | Holds the block in its reset state while high |
| cfg_promisc | input | 1 | Deliver packets regardless of destination ID |
| cfg_base_id | input | IDW | Local base ID |
| cfg_send_rst | input | 1 | Send reset-device requests on a fatal error |
| cfg_auto_sync | input | 1 | Load the transmit ackID from partner_ackid after recovery |
| partner_ackid | input | 5 | Partner's expected ackID |
| rx_valid | input | 1 | Incoming packet header valid |
| rx_ready | output | 1 | Incoming packet can be taken |
| rx_ackid | input | 5 | Incoming packet ackID |
| rx_destid | input | IDW | Incoming packet destination ID |
| rx_ack | output | 1 | Packet acknowledged at the link layer |
| rx_deliver | output | 1 | Packet passed on to the logical layer |
| tx_in_valid | input | 1 | Packet offered to the transmit queue |
| tx_in_ready | output | 1 | Transmit queue can take a packet |
| tx_in_tag | input | TAGW | Packet handle |
| tx_out_valid | output | 1 | Stamped packet available |
| tx_out_ready | input | 1 | Link takes the stamped packet |
| tx_out_tag | output | TAGW | Handle of the outgoing packet |
| tx_out_ackid | output | 5 | ackID stamped on the outgoing packet |
| sym_in_valid | input | 1 | Incoming control symbol valid |
| sym_in_rstdev | input | 1 | Incoming symbol is a reset-device request |
| sym_out_rstdev | output | 1 | Emit a reset-device request this cycle |
| peer_rst_seen | output | 1 | Fourth consecutive reset-device symbol received |
| recovering | output | 1 | Soft reset in progress |
| stat_fatal | output | 1 | Sticky fatal-error flag |
| stat_clr | input | 1 | Write-one clear of stat_fatal |
| exp_ackid | output | 5 | Expected inbound ackID |

## Verification
Receive traffic is tried with three kinds of packets. In-order ackIDs across the 31-to-0 wrap show that the counter steps correctly. Packets with a foreign destination ID, sent with promiscuous mode both off and on, separate link acknowledgement from logical delivery. A single out-of-order ackID confirms that the error is fatal. Fatal errors are raised under different option settings (sending requests on and off, automatic synchronization on and off), so the recovery length, the request count and the reloaded transmit ackID each point to one setting. Symbol runs that are broken by another symbol, or only paused by idle cycles, separate a true four-in-a-row from a near miss. A port-disable pulse with a packet queued shows that the flush and the zeroing also happen outside recovery.

// File: rtl/ackid_trk_pkg.sv
package ackid_trk_pkg;
  parameter int ACK_W = 5;
  typedef logic [ACK_W-1:0] ackid_t;

  typedef enum logic [1:0] {
    RCV_IDLE  = 2'd0,
    RCV_FLUSH = 2'd1,
    RCV_SEND  = 2'd2,
    RCV_SYNC  = 2'd3
  } rcv_state_e;

  // next ackID, wrapping modulo 2**ACK_W
  function automatic ackid_t ackid_inc(input ackid_t a);
    return ackid_t'(a + 1'b1);
  endfunction
endpackage

// File: rtl/lt_rx_check.sv
module lt_rx_check
  import ackid_trk_pkg::*;
#(
  parameter int IDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           busy,
  input  logic           rx_valid,
  input  ackid_t         rx_ackid,
  input  logic [IDW-1:0] rx_destid,
  input  logic           cfg_promisc,
  input  logic [IDW-1:0] cfg_base_id,
  output logic           rx_ready,
  output logic           acc,
  output logic           deliver,
  output logic           fatal,
  output ackid_t         exp_ackid
);
  ackid_t exp_q;
  logic   hs;

  assign rx_ready  = !busy;
  assign hs        = rx_valid && rx_ready;
  assign acc       = hs && (rx_ackid == exp_q);
  assign fatal     = hs && (rx_ackid != exp_q);
  assign deliver   = acc && (cfg_promisc || (rx_destid == cfg_base_id));
  assign exp_ackid = exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   exp_q <= '0;
    else if (clr) exp_q <= '0;
    else if (acc) exp_q <= ackid_inc(exp_q);
  end

  // R2
  exp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !clr) |=> (exp_q == ackid_inc($past(exp_q))));
endmodule

// File: rtl/lt_tx_queue.sv
module lt_tx_queue
  import ackid_trk_pkg::*;
#(
  parameter int TAGW   = 8,
  parameter int QDEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            busy,
  input  logic            id_load,
  input  ackid_t          id_val,
  input  logic            in_valid,
  input  logic [TAGW-1:0] in_tag,
  output logic            in_ready,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [TAGW-1:0] out_tag,
  output ackid_t          out_ackid
);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);

  logic [TAGW-1:0] mem [QDEPTH];
  logic [PW-1:0]   wr_q, rd_q;
  logic [CW-1:0]   cnt_q;
  ackid_t          id_q;
  logic            push, pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(QDEPTH - 1)) ? '0 : PW'(p + 1'b1);
  endfunction

  assign in_ready  = !busy && (cnt_q != CW'(QDEPTH));
  assign out_valid = !busy && (cnt_q != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_tag   = mem[rd_q];
  assign out_ackid = id_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= in_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else if (flush) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else begin
      if (push) wr_q <= ptr_inc(wr_q);
      if (pop)  rd_q <= ptr_inc(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= CW'(cnt_q + 1'b1);
        2'b01:   cnt_q <= CW'(cnt_q - 1'b1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       id_q <= '0;
    else if (id_load) id_q <= id_val;
    else if (pop)     id_q <= ackid_inc(id_q);
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(QDEPTH));
  // R10
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !id_load) |=> (out_ackid == ackid_inc($past(out_ackid))));
  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: rtl/lt_rstdev_detect.sv
module lt_rstdev_detect #(
  parameter int NRST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sym_valid,
  input  logic sym_rstdev,
  output logic hit
);
  localparam int SW = (NRST > 1) ? $clog2(NRST) : 1;
  logic [SW-1:0] cnt_q;

  assign hit = sym_valid && sym_rstdev && (cnt_q == SW'(NRST - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (sym_valid) begin
      if (!sym_rstdev || hit) cnt_q <= '0;
      else                    cnt_q <= SW'(cnt_q + 1'b1);
    end
  end

  // R8
  other_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_rstdev) |=> !hit);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/lt_recovery.sv
module lt_recovery
  import ackid_trk_pkg::*;
#(
  parameter int NRST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_dis,
  input  logic fatal,
  input  logic peer_rst,
  input  logic cfg_send,
  output logic recovering,
  output logic flush,
  output logic sym_out,
  output logic sync
);
  localparam int SW = (NRST > 1) ? $clog2(NRST) : 1;

  rcv_state_e    state_q;
  logic          cause_q;
  logic [SW-1:0] scnt_q;

  assign recovering = (state_q != RCV_IDLE);
  assign flush      = (state_q == RCV_FLUSH);
  assign sym_out    = (state_q == RCV_SEND);
  assign sync       = (state_q == RCV_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RCV_IDLE; cause_q <= 1'b0; scnt_q <= '0;
    end else if (port_dis) begin
      state_q <= RCV_IDLE; cause_q <= 1'b0; scnt_q <= '0;
    end else begin
      case (state_q)
        RCV_IDLE: begin
          if (fatal) begin
            state_q <= RCV_FLUSH; cause_q <= 1'b1;
          end else if (peer_rst) begin
            state_q <= RCV_FLUSH; cause_q <= 1'b0;
          end
        end
        RCV_FLUSH: begin
          scnt_q  <= '0;
          state_q <= (cause_q && cfg_send) ? RCV_SEND : RCV_SYNC;
        end
        RCV_SEND: begin
          if (scnt_q == SW'(NRST - 1)) state_q <= RCV_SYNC;
          else                         scnt_q  <= SW'(scnt_q + 1'b1);
        end
        default: state_q <= RCV_IDLE;
      endcase
    end
  end

  // R6
  sym_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_out |-> cause_q);
  // R4
  fatal_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal && !port_dis) |=> flush);
endmodule

// File: rtl/ackid_link_tracker.sv
module ackid_link_tracker
  import ackid_trk_pkg::*;
#(
  parameter int IDW    = 8,
  parameter int TAGW   = 8,
  parameter int QDEPTH = 4,
  parameter int NRST   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_dis,
  input  logic            cfg_promisc,
  input  logic [IDW-1:0]  cfg_base_id,
  input  logic            cfg_send_rst,
  input  logic            cfg_auto_sync,
  input  logic [4:0]      partner_ackid,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [4:0]      rx_ackid,
  input  logic [IDW-1:0]  rx_destid,
  output logic            rx_ack,
  output logic            rx_deliver,
  input  logic            tx_in_valid,
  output logic            tx_in_ready,
  input  logic [TAGW-1:0] tx_in_tag,
  output logic            tx_out_valid,
  input  logic            tx_out_ready,
  output logic [TAGW-1:0] tx_out_tag,
  output logic [4:0]      tx_out_ackid,
  input  logic            sym_in_valid,
  input  logic            sym_in_rstdev,
  output logic            sym_out_rstdev,
  output logic            peer_rst_seen,
  output logic            recovering,
  output logic            stat_fatal,
  input  logic            stat_clr,
  output logic [4:0]      exp_ackid
);
  logic   busy, fatal, rcv_flush, rcv_sync;
  logic   q_flush, id_load, fatal_q;
  ackid_t id_val;

  assign busy    = port_dis || recovering;
  assign q_flush = port_dis || rcv_flush;
  assign id_load = port_dis || rcv_sync;
  assign id_val  = (!port_dis && cfg_auto_sync) ? ackid_t'(partner_ackid) : '0;

  lt_rx_check #(.IDW(IDW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(q_flush), .busy(busy),
    .rx_valid(rx_valid), .rx_ackid(rx_ackid), .rx_destid(rx_destid),
    .cfg_promisc(cfg_promisc), .cfg_base_id(cfg_base_id),
    .rx_ready(rx_ready), .acc(rx_ack), .deliver(rx_deliver),
    .fatal(fatal), .exp_ackid(exp_ackid)
  );

  lt_tx_queue #(.TAGW(TAGW), .QDEPTH(QDEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(q_flush), .busy(busy),
    .id_load(id_load), .id_val(id_val),
    .in_valid(tx_in_valid), .in_tag(tx_in_tag), .in_ready(tx_in_ready),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready),
    .out_tag(tx_out_tag), .out_ackid(tx_out_ackid)
  );

  lt_rstdev_detect #(.NRST(NRST)) u_det (
    .clk(clk), .rst_n(rst_n), .clr(port_dis),
    .sym_valid(sym_in_valid), .sym_rstdev(sym_in_rstdev), .hit(peer_rst_seen)
  );

  lt_recovery #(.NRST(NRST)) u_rcv (
    .clk(clk), .rst_n(rst_n), .port_dis(port_dis), .fatal(fatal),
    .peer_rst(peer_rst_seen), .cfg_send(cfg_send_rst),
    .recovering(recovering), .flush(rcv_flush),
    .sym_out(sym_out_rstdev), .sync(rcv_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fatal_q <= 1'b0;
    else if (fatal)    fatal_q <= 1'b1;
    else if (stat_clr) fatal_q <= 1'b0;
  end
  assign stat_fatal = fatal_q;

  // R1
  dis_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_dis |=> (exp_ackid == '0) && !tx_out_valid);
  // R4
  rec_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovering |-> !rx_ready && !tx_in_ready);
  // R9
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> stat_fatal);
  // R8
  peer_no_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_rst_seen && !fatal && !stat_fatal && !busy) |=> recovering && !stat_fatal);
endmodule

// File: tb/test_ackid_link_tracker.sv
module test_ackid_link_tracker;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_dis = 1'b0;
  logic       cfg_promisc = 1'b0;
  logic [7:0] cfg_base_id = 8'h21;
  logic       cfg_send_rst = 1'b0;
  logic       cfg_auto_sync = 1'b0;
  logic [4:0] partner_ackid = 5'd0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [4:0] rx_ackid = 5'd0;
  logic [7:0] rx_destid = 8'h21;
  logic       rx_ack, rx_deliver;
  logic       tx_in_valid = 1'b0;
  logic       tx_in_ready;
  logic [7:0] tx_in_tag = 8'h0;
  logic       tx_out_valid;
  logic       tx_out_ready = 1'b0;
  logic [7:0] tx_out_tag;
  logic [4:0] tx_out_ackid;
  logic       sym_in_valid = 1'b0;
  logic       sym_in_rstdev = 1'b0;
  logic       sym_out_rstdev, peer_rst_seen, recovering, stat_fatal;
  logic       stat_clr = 1'b0;
  logic [4:0] exp_ackid;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] sb[$];
  int tb_txid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ackid_link_tracker i_ackid_link_tracker (.*);

  task automatic chk_eq(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // scoreboard monitor: compares each outgoing handshake with the queue
  always @(negedge clk) begin
    #2;
    if (rst_n && tx_out_valid && tx_out_ready) begin
      if (sb.size() == 0) chk_eq("R10 unexpected packet", 1, 0);
      else begin
        logic [7:0] t;
        t = sb.pop_front();
        chk_eq("R10 tag order", int'(tx_out_tag), int'(t));
        chk_eq("R10 ackid stamp", int'(tx_out_ackid), tb_txid);
        tb_txid = (tb_txid + 1) % 32;
      end
    end
  end

  task automatic tx_push(input logic [7:0] tag, input int ok, input string req);
    @(negedge clk);
    tx_in_valid = 1'b1; tx_in_tag = tag;
    #1;
    chk_eq(req, int'(tx_in_ready), ok);
    if (tx_in_ready) sb.push_back(tag);
    @(negedge clk);
    tx_in_valid = 1'b0;
  endtask

  task automatic drain();
    tx_out_ready = 1'b1;
    for (int i = 0; i < 40 && sb.size() != 0; i++) @(negedge clk);
    #3;
    chk_eq("R10 queue drained", sb.size(), 0);
    tx_out_ready = 1'b0;
  endtask

  task automatic rx_send(input int aid, input int dest, input int eack, input int edel, input string req);
    @(negedge clk);
    rx_valid = 1'b1; rx_ackid = 5'(aid); rx_destid = 8'(dest);
    #1;
    chk_eq({req, " ack"}, int'(rx_ack), eack);
    chk_eq({req, " deliver"}, int'(rx_deliver), edel);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic fatal_run(input int bad, output int len, output int syms);
    @(negedge clk);
    rx_valid = 1'b1; rx_ackid = 5'(bad);
    #1;
    chk_eq("R4 no ack on mismatch", int'(rx_ack), 0);
    @(negedge clk);
    rx_valid = 1'b0;
    #1;
    chk_eq("R4 recovering", int'(recovering), 1);
    chk_eq("R4 rx_ready low", int'(rx_ready), 0);
    chk_eq("R4 tx_in_ready low", int'(tx_in_ready), 0);
    chk_eq("R4 stat_fatal set", int'(stat_fatal), 1);
    len = 0; syms = 0;
    while (recovering && len < 50) begin
      len++; syms += int'(sym_out_rstdev);
      @(negedge clk); #1;
    end
  endtask

  task automatic sym(input int v, input int r, input int ehit, input string req);
    @(negedge clk);
    sym_in_valid = v[0]; sym_in_rstdev = r[0];
    #1;
    chk_eq(req, int'(peer_rst_seen), ehit);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int len, syms;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk_eq("R1 exp_ackid after reset", int'(exp_ackid), 0);
    chk_eq("R1 no tx after reset", int'(tx_out_valid), 0);
    chk_eq("R1 stat clear after reset", int'(stat_fatal), 0);
    chk_eq("R1 rx_ready after reset", int'(rx_ready), 1);

    // R10 fill to depth, then overflow attempt, then drain in order
    for (int i = 0; i < 4; i++) tx_push(8'(8'hA0 + i), 1, "R10 push accepted");
    tx_push(8'hEE, 0, "R10 full blocks push");
    drain();
    tx_out_ready = 1'b1;
    for (int i = 0; i < 3; i++) tx_push(8'(8'hB0 + i), 1, "R10 streaming push");
    drain();

    // R2 in-order receive across the wrap
    for (int i = 0; i < 33; i++) rx_send(i % 32, 8'h21, 1, 1, "R2 in-order");
    chk_eq("R2 exp wraps to 1", int'(exp_ackid), 1);

    // R3 destination filter
    rx_send(1, 8'h55, 1, 0, "R3 foreign dest filtered");
    cfg_promisc = 1'b1;
    rx_send(2, 8'h55, 1, 1, "R3 promiscuous delivers");
    cfg_promisc = 1'b0;
    chk_eq("R3 exp still advances", int'(exp_ackid), 3);

    // R4/R5/R6/R7 fatal with requests sent, no auto sync
    cfg_send_rst = 1'b1; cfg_auto_sync = 1'b0;
    tx_push(8'hC0, 1, "R5 queued before fatal");
    tx_push(8'hC1, 1, "R5 queued before fatal");
    fatal_run(9, len, syms);
    sb.delete();
    chk_eq("R6 recovery length with send", len, 6);
    chk_eq("R6 four requests sent", syms, 4);
    chk_eq("R5 queue flushed", int'(tx_out_valid), 0);
    chk_eq("R5 exp back to zero", int'(exp_ackid), 0);
    chk_eq("R9 sticky after recovery", int'(stat_fatal), 1);
    tb_txid = 0; // R7 without auto sync the stamp restarts at zero
    tx_out_ready = 1'b1;
    tx_push(8'hC2, 1, "R5 push after recovery");
    drain();
    rx_send(0, 8'h21, 1, 1, "R5 receive resumes");

    // R9 write-one clear
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0; #1;
    chk_eq("R9 cleared by stat_clr", int'(stat_fatal), 0);

    // R6/R7 fatal without requests, with auto sync
    cfg_send_rst = 1'b0; cfg_auto_sync = 1'b1; partner_ackid = 5'd17;
    fatal_run(9, len, syms);
    chk_eq("R6 recovery length without send", len, 2);
    chk_eq("R6 no requests sent", syms, 0);
    tb_txid = 17;
    tx_push(8'hD0, 1, "R7 push after sync");
    #1;
    chk_eq("R7 auto-sync stamp", int'(tx_out_ackid), 17);
    drain();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;

    // R8 reset-device symbol runs
    cfg_send_rst = 1'b1; cfg_auto_sync = 1'b0;
    sym(1, 1, 0, "R8 run 1");
    sym(1, 1, 0, "R8 run 2");
    sym(1, 1, 0, "R8 run 3");
    sym(1, 0, 0, "R8 other symbol restarts");
    sym(1, 1, 0, "R8 restart 1");
    sym(1, 1, 0, "R8 restart 2");
    sym(1, 1, 0, "R8 restart 3");
    sym(0, 1, 0, "R8 idle cycle ignored");
    sym(1, 1, 1, "R8 fourth in a row");
    @(negedge clk);
    sym_in_valid = 1'b0;
    #1;
    len = 0; syms = 0;
    while (recovering && len < 50) begin
      len++; syms += int'(sym_out_rstdev);
      @(negedge clk); #1;
    end
    chk_eq("R8 peer reset recovery length", len, 2);
    chk_eq("R8 no requests on peer reset", syms, 0);
    chk_eq("R8 no fatal flag", int'(stat_fatal), 0);
    tb_txid = 0;

    // R1 port disable with traffic pending
    rx_send(0, 8'h21, 1, 1, "R1 pre-disable receive");
    tx_push(8'hE0, 1, "R1 queued before disable");
    @(negedge clk); port_dis = 1'b1; #1;
    chk_eq("R1 rx_ready low while disabled", int'(rx_ready), 0);
    chk_eq("R1 tx_in_ready low while disabled", int'(tx_in_ready), 0);
    chk_eq("R1 tx_out_valid low while disabled", int'(tx_out_valid), 0);
    @(negedge clk); #1;
    chk_eq("R1 exp zero while disabled", int'(exp_ackid), 0);
    @(negedge clk); port_dis = 1'b0; #1;
    sb.delete();
    chk_eq("R1 queue flushed by disable", int'(tx_out_valid), 0);
    tb_txid = 0;
    tx_push(8'hE1, 1, "R1 push after disable");
    drain();

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule